// File: doc/BRIEF.md
# Packed BCD Add-with-Extend Unit

This unit adds two packed BCD bytes and an incoming extend bit, one decimal digit at a time. It produces a packed BCD byte and the condition flags that follow from it. It reproduces the processor's exact arithmetic for every one of the 2 × 256 × 256 input combinations, including bytes whose nibbles are not valid decimal digits.

The low digit is handled first. Its decimal correction carries into the high digit, and a second correction on the high digit produces the decimal carry out. The carry goes to both the extend flag and the carry flag. The zero flag is sticky: a nonzero result clears it, and a zero result passes the incoming value through unchanged. The negative and overflow flags are never computed. A hold indication tells the surrounding pipeline to keep their old values.

A sequencer, enabled by a parameter, computes the two predecremented byte addresses for the memory-to-memory form. The caller supplies:
- the register indices of the source and destination pointers;
- their current contents.

A single-cycle start pulse captures all inputs. Result, flags and addresses appear together with a one-cycle valid pulse on the next clock. A new start may be issued on every cycle.

Top module: `bcd_xadd`

## Requirements
- R1: `valid_o` is high in exactly the cycle after a cycle in which `start_i` was sampled high, and low otherwise.
- R2: Low digit step: the running sum starts at `x_i`, and the low nibbles of both operands are added to it. If this sum is 10 or more, 6 is added to it, which is the same as adding 0x10 and subtracting 10.
- R3: High digit step: the high nibbles, kept in their upper-nibble positions, are added to the running sum. If the total is 0xA0 or more, 0x60 is added. `result_o` is bits 7:0 of the final sum, for any byte values, valid BCD or not. Examples: 0xF7 + 0xFF with X=1 gives 0x5D; 0x05 + 0x05 with X=0 gives 0x10.
- R4: `x_o` and `c_o` are both 1 when the final sum is 0x100 or more, and both 0 otherwise.
- R5: `z_o` is 0 when `result_o` is nonzero. Otherwise it equals the `z_i` value captured with the start.
- R6: `nv_hold_o` is high whenever `valid_o` is high. This signals that N and V keep their previous values.
- R7: `src_ea_o` is the source register contents minus 2 when `src_idx_i` is 7 (the stack pointer), and minus 1 otherwise.
- R8: The destination base is `src_ea_o` when `src_idx_i` equals `dst_idx_i`, so that the two decrements accumulate. Otherwise the base is `dst_areg_i`. `dst_ea_o` is that base minus 2 when `dst_idx_i` is 7, and minus 1 otherwise.
- R9: While reset is active, and after it, until the first start: `valid_o`, `result_o`, all flags and both addresses are 0.
- R10: With no start, result, flags and addresses hold their last values, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Capture operands and begin the add |
| opa_i | input | 8 | Source packed BCD byte |
| opb_i | input | 8 | Destination packed BCD byte |
| x_i | input | 1 | Incoming extend flag |
| z_i | input | 1 | Incoming zero flag |
| src_idx_i | input | 3 | Source pointer register index |
| dst_idx_i | input | 3 | Destination pointer register index |
| src_areg_i | input | 32 | Source pointer register contents |
| dst_areg_i | input | 32 | Destination pointer register contents |
| valid_o | output | 1 | One-cycle result strobe |
| result_o | output | 8 | Packed BCD sum |
| x_o | output | 1 | New extend flag |
| c_o | output | 1 | New carry flag |
| z_o | output | 1 | New zero flag (sticky) |
| nv_hold_o | output | 1 | Keep N and V unchanged |
| src_ea_o | output | 32 | Predecremented source address |
| dst_ea_o | output | 32 | Predecremented destination address |

## Verification
The bench sweeps every extend value and every pair of bytes. This exercises the invalid-digit cases that a design built on decimal modulo arithmetic would get wrong: 0xF7 + 0xFF would come out as something other than 0x5D. Zero results are paired with both incoming Z values. A unit that set Z on a zero result, instead of leaving it alone, would fail on every zero sum where `z_i` is 0. Register indices cycle through all pairs, including index 7 and matching indices. A sequencer that always stepped by one, or did not chain the two decrements, shows a wrong destination address. Idle cycles with changing inputs catch outputs that are not held.

// File: rtl/bcd_xadd_pkg.sv
package bcd_xadd_pkg;
    localparam int NIB_W   = 4;
    localparam int DEC_LIM = 10;
    localparam int DEC_ADJ = 6;

    typedef struct packed {
        logic x;
        logic c;
        logic z;
    } bcd_flags_t;
endpackage

// File: rtl/bcd_digit_stage.sv
module bcd_digit_stage #(
    parameter int SW  = 10,
    parameter int POS = 0
) (
    input  logic [SW-1:0]                    acc_i,
    input  logic [bcd_xadd_pkg::NIB_W-1:0]   a_nib_i,
    input  logic [bcd_xadd_pkg::NIB_W-1:0]   b_nib_i,
    output logic [SW-1:0]                    acc_o
);
    import bcd_xadd_pkg::*;

    localparam int SH = NIB_W * POS;
    localparam logic [SW-1:0] LIM = SW'(DEC_LIM) << SH;
    localparam logic [SW-1:0] ADJ = SW'(DEC_ADJ) << SH;

    logic [SW-1:0] raw;

    always_comb begin
        raw   = acc_i + (SW'(a_nib_i) << SH) + (SW'(b_nib_i) << SH);
        acc_o = (raw >= LIM) ? raw + ADJ : raw;
    end
endmodule

// File: rtl/bcd_predec_addr.sv
module bcd_predec_addr #(
    parameter int AW = 32,
    parameter int RW = 3
) (
    input  logic [RW-1:0] src_idx_i,
    input  logic [RW-1:0] dst_idx_i,
    input  logic [AW-1:0] src_val_i,
    input  logic [AW-1:0] dst_val_i,
    output logic [AW-1:0] src_ea_o,
    output logic [AW-1:0] dst_ea_o
);
    localparam logic [RW-1:0] SP_IDX = {RW{1'b1}};

    logic [AW-1:0] src_step;
    logic [AW-1:0] dst_step;
    logic [AW-1:0] dst_base;

    always_comb begin
        src_step = (src_idx_i == SP_IDX) ? AW'(2) : AW'(1);
        dst_step = (dst_idx_i == SP_IDX) ? AW'(2) : AW'(1);
        src_ea_o = src_val_i - src_step;
        dst_base = (src_idx_i == dst_idx_i) ? src_ea_o : dst_val_i;
        dst_ea_o = dst_base - dst_step;
    end
endmodule

// File: rtl/bcd_xadd.sv
module bcd_xadd #(
    parameter int DIGITS   = 2,
    parameter int AW       = 32,
    parameter int RW       = 3,
    parameter bit HAS_ADDR = 1'b1,
    localparam int W       = bcd_xadd_pkg::NIB_W * DIGITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [W-1:0]  opa_i,
    input  logic [W-1:0]  opb_i,
    input  logic          x_i,
    input  logic          z_i,
    input  logic [RW-1:0] src_idx_i,
    input  logic [RW-1:0] dst_idx_i,
    input  logic [AW-1:0] src_areg_i,
    input  logic [AW-1:0] dst_areg_i,
    output logic          valid_o,
    output logic [W-1:0]  result_o,
    output logic          x_o,
    output logic          c_o,
    output logic          z_o,
    output logic          nv_hold_o,
    output logic [AW-1:0] src_ea_o,
    output logic [AW-1:0] dst_ea_o
);
    import bcd_xadd_pkg::*;

    localparam int SW = W + 2;

    typedef struct packed {
        logic          valid;
        logic [W-1:0]  res;
        bcd_flags_t    flg;
        logic [AW-1:0] sea;
        logic [AW-1:0] dea;
    } out_t;

    out_t out_d, out_q;

    logic [SW-1:0] acc [0:DIGITS];
    logic [AW-1:0] sea_c, dea_c;
    logic          carry;
    logic [W-1:0]  sum_lo;

    assign acc[0] = SW'(x_i);

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        bcd_digit_stage #(.SW(SW), .POS(g)) stage_i (
            .acc_i   (acc[g]),
            .a_nib_i (opa_i[g*NIB_W +: NIB_W]),
            .b_nib_i (opb_i[g*NIB_W +: NIB_W]),
            .acc_o   (acc[g+1])
        );
    end

    if (HAS_ADDR) begin : g_addr
        bcd_predec_addr #(.AW(AW), .RW(RW)) addr_i (
            .src_idx_i (src_idx_i),
            .dst_idx_i (dst_idx_i),
            .src_val_i (src_areg_i),
            .dst_val_i (dst_areg_i),
            .src_ea_o  (sea_c),
            .dst_ea_o  (dea_c)
        );
    end else begin : g_noaddr
        assign sea_c = '0;
        assign dea_c = '0;
    end

    assign sum_lo = acc[DIGITS][W-1:0];
    assign carry  = |acc[DIGITS][SW-1:W];

    always_comb begin
        out_d       = out_q;
        out_d.valid = start_i;
        if (start_i) begin
            out_d.res   = sum_lo;
            out_d.flg.x = carry;
            out_d.flg.c = carry;
            out_d.flg.z = (sum_lo != '0) ? 1'b0 : z_i;
            out_d.sea   = sea_c;
            out_d.dea   = dea_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign valid_o   = out_q.valid;
    assign nv_hold_o = out_q.valid;
    assign result_o  = out_q.res;
    assign x_o       = out_q.flg.x;
    assign c_o       = out_q.flg.c;
    assign z_o       = out_q.flg.z;
    assign src_ea_o  = out_q.sea;
    assign dst_ea_o  = out_q.dea;
endmodule

// File: rtl/bcd_xadd_chk.sv
module bcd_xadd_chk #(
    parameter int W        = 8,
    parameter int AW       = 32,
    parameter int RW       = 3,
    parameter bit HAS_ADDR = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          z_i,
    input logic [RW-1:0] src_idx_i,
    input logic [AW-1:0] src_areg_i,
    input logic          valid_o,
    input logic [W-1:0]  result_o,
    input logic          x_o,
    input logic          c_o,
    input logic          z_o,
    input logic          nv_hold_o,
    input logic [AW-1:0] src_ea_o
);
    localparam logic [RW-1:0] SP_IDX = {RW{1'b1}};

    AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n) start_i |=> valid_o); // R1
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n) !start_i |=> !valid_o); // R1
    AST_XC_AGREE: assert property (@(posedge clk) disable iff (!rst_n) valid_o |-> (x_o == c_o)); // R4
    AST_Z_NEVER_SET: assert property (@(posedge clk) disable iff (!rst_n) (start_i && !z_i) |=> !z_o); // R5
    AST_Z_CLEAR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) (valid_o && result_o != '0) |-> !z_o); // R5
    AST_NV_HOLD: assert property (@(posedge clk) disable iff (!rst_n) valid_o |-> nv_hold_o); // R6
    AST_SRC_PREDEC: assert property (@(posedge clk) disable iff (!rst_n) (start_i && HAS_ADDR) |=> src_ea_o == $past(src_areg_i) - (($past(src_idx_i) == SP_IDX) ? AW'(2) : AW'(1))); // R7
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !start_i |=> ($stable(result_o) && $stable(z_o) && $stable(c_o))); // R10
endmodule

bind bcd_xadd bcd_xadd_chk #(.W(W), .AW(AW), .RW(RW), .HAS_ADDR(HAS_ADDR)) chk_i (.*);

// File: tb/bcd_xadd_tb_top.sv
module bcd_xadd_tb_top;
    localparam int CLK_PER = 10;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [7:0]    opa_i = '0, opb_i = '0;
    logic          x_i = 1'b0, z_i = 1'b0;
    logic [2:0]    src_idx_i = '0, dst_idx_i = '0;
    logic [AW-1:0] src_areg_i = '0, dst_areg_i = '0;
    logic          valid_o, x_o, c_o, z_o, nv_hold_o;
    logic [7:0]    result_o;
    logic [AW-1:0] src_ea_o, dst_ea_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    int          exp_res_q[$];
    bit          exp_x_q[$];
    bit          exp_z_q[$];
    logic [31:0] exp_sea_q[$];
    logic [31:0] exp_dea_q[$];

    int          last_res = 0;
    bit          last_x = 0, last_z = 0;
    logic [31:0] last_sea = '0, last_dea = '0;

    bcd_xadd dut_i (.*);

    always #(CLK_PER/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int ref_sum(input int a, input int b, input int x);
        int s;
        s = x + (a % 16) + (b % 16);
        if (s >= 10) s = s + 16 - 10;
        s = s + (a / 16) * 16 + (b / 16) * 16;
        if (s >= 160) s = s + 256 - 160;
        return s;
    endfunction

    function automatic logic [31:0] step_of(input int idx);
        return (idx == 7) ? 32'd2 : 32'd1;
    endfunction

    // called just after a falling edge: check what the previous cycle produced
    task automatic compare_cycle();
        if (exp_res_q.size() > 0) begin
            int r;
            r = exp_res_q.pop_front();
            chk("R1 valid", 32'(valid_o), 32'd1);
            chk("R2/R3 result", 32'(result_o), 32'(r));
            chk("R4 x", 32'(x_o), 32'(exp_x_q[0]));
            chk("R4 c", 32'(c_o), 32'(exp_x_q.pop_front()));
            chk("R5 z", 32'(z_o), 32'(exp_z_q.pop_front()));
            chk("R6 nv_hold", 32'(nv_hold_o), 32'd1);
            chk("R7 src_ea", src_ea_o, exp_sea_q.pop_front());
            chk("R8 dst_ea", dst_ea_o, exp_dea_q.pop_front());
        end else begin
            chk("R1 idle valid", 32'(valid_o), 32'd0);
            chk("R10 hold result", 32'(result_o), 32'(last_res));
            chk("R10 hold z", 32'(z_o), 32'(last_z));
            chk("R10 hold c", 32'(c_o), 32'(last_x));
            chk("R10 hold src_ea", src_ea_o, last_sea);
            chk("R10 hold dst_ea", dst_ea_o, last_dea);
        end
    endtask

    task automatic drive(input bit go, input int a, input int b, input int x, input int z,
                         input int si, input int di, input logic [31:0] sv, input logic [31:0] dv);
        start_i = go; opa_i = 8'(a); opb_i = 8'(b); x_i = x[0]; z_i = z[0];
        src_idx_i = 3'(si); dst_idx_i = 3'(di); src_areg_i = sv; dst_areg_i = dv;
        if (go) begin
            int s;
            logic [31:0] se, db;
            s  = ref_sum(a, b, x);
            se = sv - step_of(si);
            db = (si == di) ? se : dv;
            last_res = s % 256;
            last_x   = (s >= 256);
            last_z   = (last_res != 0) ? 1'b0 : z[0];
            last_sea = se;
            last_dea = db - step_of(di);
            exp_res_q.push_back(last_res);
            exp_x_q.push_back(last_x);
            exp_z_q.push_back(last_z);
            exp_sea_q.push_back(last_sea);
            exp_dea_q.push_back(last_dea);
        end
        @(negedge clk);
        compare_cycle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 reset valid", 32'(valid_o), 32'd0);
        chk("R9 reset result", 32'(result_o), 32'd0);
        chk("R9 reset flags", 32'({x_o, c_o, z_o}), 32'd0);
        chk("R9 reset addr", src_ea_o | dst_ea_o, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 post-reset valid", 32'(valid_o), 32'd0);

        // named corner cases
        drive(1, 8'hF7, 8'hFF, 1, 0, 0, 1, 32'h100, 32'h200);   // R3 invalid digits -> 5D, R4 carry
        drive(1, 8'h05, 8'h05, 0, 0, 7, 7, 32'h400, 32'h400);   // R2 low correction -> 10, R8 SP chain
        drive(1, 8'h99, 8'h01, 0, 1, 3, 3, 32'h10, 32'h90);     // R5 zero result keeps z=1, R8 same reg
        drive(1, 8'h00, 8'h00, 0, 0, 2, 7, 32'h0, 32'h0);       // R5 zero result keeps z=0, R7 wrap
        drive(0, 8'h12, 8'h34, 1, 1, 5, 6, 32'hAAAA, 32'h5555); // R10 hold with new inputs
        drive(0, 8'h77, 8'h88, 0, 0, 1, 1, 32'h1, 32'h2);       // R10 hold again

        // exhaustive sweep, one start per cycle
        for (int i = 0; i < 2 * 256 * 256; i++) begin
            int a, b, x;
            a = i % 256;
            b = (i / 256) % 256;
            x = i / 65536;
            drive(1, a, b, x, (a ^ (b >> 3)) & 1, i % 8, (i / 8) % 8,
                  32'h1000 + 32'(i) * 3, 32'h8000_0001 ^ (32'(i) << 4));
        end
        drive(0, 0, 0, 0, 0, 0, 0, 32'h0, 32'h0);
        drive(0, 8'hFF, 8'hFF, 1, 1, 7, 7, 32'hFFFF, 32'hFFFF);
        done = 1;
    end

    initial begin
        wait (done || cyc >= 190000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule